// File: doc/BRIEF.md
# Processor Clock-State Sequencer

This controller sits on the system side of a processor and walks it through four clock states: Normal, Stop Grant, Sleep and Deep Sleep. It drives an active-low stop-clock strobe, an active-low sleep strobe, an enable for the bus-clock gate and an enable for the slow interrupt-controller clock. Single-cycle request pulses ask it to enter Stop Grant, return to Normal, enter or leave Sleep, enter or leave Deep Sleep, or reset the processor. A stop-grant acknowledge from the processor completes Stop Grant entry.

Timed transitions are counted in reference-clock cycles by one shared down-counter. Leaving Sleep for Stop Grant and leaving Stop Grant for Normal each take `EXIT_CYC` cycles. Leaving Deep Sleep takes `RELOCK_CYC` cycles, which is the wait for the PLL to relock after the bus clock restarts. While any transition is in progress, `busy` is high and every request other than reset is ignored. A reset request is forwarded as a one-cycle pulse, except while the bus clock is stopped or relocking. In that case the request is refused and an error pulse is raised instead.

Top module: `clkstate_seq`

## Requirements
- R1: After reset, `level` is Normal (2'b00), `stpclk_n`, `slp_n`, `bclk_en` and `pic_en` are all 1, `busy` is 0 and `ready` is 1.
- R2: A `grant_req` pulse in Normal drives `stpclk_n` low on the next cycle. `busy` then stays high and `level` stays 2'b00 until `sg_ack` is sampled, and on the cycle after that `level` becomes Stop Grant (2'b01) with `busy` low.
- R3: A `sleep_req` pulse in any state other than settled Stop Grant has no effect: `slp_n`, `level` and all other outputs keep the values they would have had without it.
- R4: A `sleep_req` pulse in settled Stop Grant drives `slp_n` and `pic_en` low on the next cycle and sets `level` to Sleep (2'b10). `stpclk_n` stays low.
- R5: A `deep_req` pulse in settled Sleep drives `bclk_en` low on the next cycle, so the external gate parks the bus clock low, and sets `level` to Deep Sleep (2'b11).
- R6: A `deep_exit_req` pulse in Deep Sleep raises `bclk_en` and `pic_en` together on the next cycle. `busy` then stays high and `level` stays 2'b11 for `RELOCK_CYC` cycles. `level` then becomes Sleep, with `pic_en` low and `busy` low.
- R7: A `wake_req` pulse in settled Sleep raises `slp_n` on the next cycle while `stpclk_n` stays low. `busy` stays high and `level` stays 2'b10 for `EXIT_CYC` cycles. `level` then becomes Stop Grant with `pic_en` high.
- R8: A `resume_req` pulse in settled Stop Grant raises `stpclk_n` on the next cycle. `busy` stays high and `level` stays 2'b01 for `EXIT_CYC` cycles, and then `level` becomes Normal.
- R9: A `rst_req` pulse outside Deep Sleep and relock raises `rst_out` for exactly one cycle. In that same cycle `stpclk_n` and `slp_n` are both 1, `bclk_en` is 1 and `level` is Normal. This holds even when the request arrives in Sleep or during a transition.
- R10: A `rst_req` pulse in Deep Sleep or during relock raises `rst_err` for one cycle, leaves `rst_out` at 0 and changes no other output.
- R11: While `busy` is high, pulses on `grant_req`, `resume_req`, `sleep_req`, `wake_req`, `deep_req` and `deep_exit_req` are ignored.
- R12: `stpclk_n` and `slp_n` stay unchanged while settled in Sleep, throughout Deep Sleep, and across the relock interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant_req | input | 1 | Request to enter Stop Grant from Normal |
| resume_req | input | 1 | Request to return from Stop Grant to Normal |
| sleep_req | input | 1 | Request to enter Sleep from Stop Grant |
| wake_req | input | 1 | Request to leave Sleep for Stop Grant |
| deep_req | input | 1 | Request to enter Deep Sleep from Sleep |
| deep_exit_req | input | 1 | Request to leave Deep Sleep |
| rst_req | input | 1 | Request to reset the processor |
| sg_ack | input | 1 | Stop-grant acknowledge from the processor |
| stpclk_n | output | 1 | Stop-clock strobe, active low |
| slp_n | output | 1 | Sleep strobe, active low |
| bclk_en | output | 1 | Bus-clock gate enable (0 parks the clock low) |
| pic_en | output | 1 | Interrupt-controller clock enable |
| rst_out | output | 1 | One-cycle processor reset pulse |
| rst_err | output | 1 | One-cycle pulse for a refused reset request |
| level | output | 2 | Current state: 00 Normal, 01 Stop Grant, 10 Sleep, 11 Deep Sleep |
| busy | output | 1 | A transition is in progress |
| ready | output | 1 | Settled in the state shown on `level` |

## Verification
The assertions assume that requests are single-cycle pulses, that `sg_ack` arrives only after the stop-clock strobe is low, and that `rst_req` and `deep_exit_req` never arrive in the same cycle. The stimulus keeps to these assumptions. It raises at most one request per cycle, waits at least one idle cycle before the acknowledge, and places each illegal or ignored request where the reference model predicts no change. The first cycle after reset is clean for the `$past` checks because the state is Normal throughout the reset-release delay.

// File: rtl/clkstate_pkg.sv
package clkstate_pkg;
  typedef enum logic [2:0] {
    CS_RUN, CS_GNT_WAIT, CS_GNT, CS_GNT_EXIT,
    CS_SLP, CS_SLP_EXIT, CS_DEEP, CS_RELOCK
  } cs_state_e;

  localparam logic [1:0] LVL_RUN  = 2'b00;
  localparam logic [1:0] LVL_GNT  = 2'b01;
  localparam logic [1:0] LVL_SLP  = 2'b10;
  localparam logic [1:0] LVL_DEEP = 2'b11;

  typedef struct packed {
    logic       stpclk_n;
    logic       slp_n;
    logic       bclk_en;
    logic       pic_en;
    logic       busy;
    logic [1:0] level;
  } cs_out_t;
endpackage

// File: rtl/clkstate_timer.sv
module clkstate_timer #(
  parameter int EXIT_CYC   = 10,
  parameter int RELOCK_CYC = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_relock,
  output logic done
);
  localparam int MAXC = (RELOCK_CYC > EXIT_CYC) ? RELOCK_CYC : EXIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] EXIT_LD   = CW'(EXIT_CYC - 1);
  localparam logic [CW-1:0] RELOCK_LD = CW'(RELOCK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = sel_relock ? RELOCK_LD : EXIT_LD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/clkstate_fsm.sv
module clkstate_fsm
  import clkstate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      grant_req,
  input  logic      resume_req,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      deep_req,
  input  logic      deep_exit_req,
  input  logic      rst_req,
  input  logic      sg_ack,
  input  logic      tmr_done,
  output cs_state_e st_q,
  output logic      tmr_load,
  output logic      tmr_relock,
  output logic      rst_out,
  output logic      rst_err
);
  cs_state_e st_d;
  logic      fwd_d, bad_d, clk_off;

  assign clk_off = (st_q == CS_DEEP) || (st_q == CS_RELOCK);

  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_relock = 1'b0;
    fwd_d      = 1'b0;
    bad_d      = 1'b0;
    unique case (st_q)
      CS_RUN:      if (grant_req) st_d = CS_GNT_WAIT;
      CS_GNT_WAIT: if (sg_ack) st_d = CS_GNT;
      CS_GNT: begin
        if (sleep_req) st_d = CS_SLP;
        else if (resume_req) begin
          st_d     = CS_GNT_EXIT;
          tmr_load = 1'b1;
        end
      end
      CS_GNT_EXIT: if (tmr_done) st_d = CS_RUN;
      CS_SLP: begin
        if (deep_req) st_d = CS_DEEP;
        else if (wake_req) begin
          st_d     = CS_SLP_EXIT;
          tmr_load = 1'b1;
        end
      end
      CS_SLP_EXIT: if (tmr_done) st_d = CS_GNT;
      CS_DEEP: begin
        if (deep_exit_req) begin
          st_d       = CS_RELOCK;
          tmr_load   = 1'b1;
          tmr_relock = 1'b1;
        end
      end
      CS_RELOCK:   if (tmr_done) st_d = CS_SLP;
      default:     st_d = CS_RUN;
    endcase
    if (rst_req) begin
      if (clk_off) begin
        bad_d = 1'b1;
      end else begin
        st_d     = CS_RUN;
        fwd_d    = 1'b1;
        tmr_load = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_RUN;
      rst_out <= 1'b0;
      rst_err <= 1'b0;
    end else begin
      st_q    <= st_d;
      rst_out <= fwd_d;
      rst_err <= bad_d;
    end
  end
endmodule

// File: rtl/clkstate_outdec.sv
module clkstate_outdec
  import clkstate_pkg::*;
(
  input  cs_state_e st,
  output cs_out_t   o
);
  always_comb begin
    o = '{stpclk_n: 1'b0, slp_n: 1'b1, bclk_en: 1'b1, pic_en: 1'b1,
          busy: 1'b0, level: LVL_RUN};
    unique case (st)
      CS_RUN:      o.stpclk_n = 1'b1;
      CS_GNT_WAIT: o.busy = 1'b1;
      CS_GNT:      o.level = LVL_GNT;
      CS_GNT_EXIT: begin o.stpclk_n = 1'b1; o.busy = 1'b1; o.level = LVL_GNT; end
      CS_SLP:      begin o.slp_n = 1'b0; o.pic_en = 1'b0; o.level = LVL_SLP; end
      CS_SLP_EXIT: begin o.busy = 1'b1; o.level = LVL_SLP; end
      CS_DEEP: begin
        o.slp_n = 1'b0; o.bclk_en = 1'b0; o.pic_en = 1'b0; o.level = LVL_DEEP;
      end
      CS_RELOCK:   begin o.slp_n = 1'b0; o.busy = 1'b1; o.level = LVL_DEEP; end
      default:     o.stpclk_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/clkstate_seq.sv
module clkstate_seq
  import clkstate_pkg::*;
#(
  parameter int EXIT_CYC   = 10,
  parameter int RELOCK_CYC = 3000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant_req,
  input  logic       resume_req,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       deep_req,
  input  logic       deep_exit_req,
  input  logic       rst_req,
  input  logic       sg_ack,
  output logic       stpclk_n,
  output logic       slp_n,
  output logic       bclk_en,
  output logic       pic_en,
  output logic       rst_out,
  output logic       rst_err,
  output logic [1:0] level,
  output logic       busy,
  output logic       ready
);
  logic [1:0] sync_q;
  logic       rst_int_n;
  cs_state_e  st;
  logic       tmr_load, tmr_relock, tmr_done;
  cs_out_t    dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  clkstate_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .grant_req(grant_req), .resume_req(resume_req), .sleep_req(sleep_req),
    .wake_req(wake_req), .deep_req(deep_req), .deep_exit_req(deep_exit_req),
    .rst_req(rst_req), .sg_ack(sg_ack), .tmr_done(tmr_done),
    .st_q(st), .tmr_load(tmr_load), .tmr_relock(tmr_relock),
    .rst_out(rst_out), .rst_err(rst_err)
  );

  clkstate_timer #(.EXIT_CYC(EXIT_CYC), .RELOCK_CYC(RELOCK_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load),
    .sel_relock(tmr_relock), .done(tmr_done)
  );

  clkstate_outdec u_dec (.st(st), .o(dec));

  assign stpclk_n = dec.stpclk_n;
  assign slp_n    = dec.slp_n;
  assign bclk_en  = dec.bclk_en;
  assign pic_en   = dec.pic_en;
  assign level    = dec.level;
  assign busy     = dec.busy;
  assign ready    = !dec.busy;
endmodule

// File: rtl/clkstate_chk.sv
module clkstate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       grant_req,
  input logic       resume_req,
  input logic       sleep_req,
  input logic       wake_req,
  input logic       deep_req,
  input logic       deep_exit_req,
  input logic       rst_req,
  input logic       sg_ack,
  input logic       stpclk_n,
  input logic       slp_n,
  input logic       bclk_en,
  input logic       pic_en,
  input logic       rst_out,
  input logic       rst_err,
  input logic [1:0] level,
  input logic       busy,
  input logic       ready
);
  // R3
  sleep_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_n) |-> ($past(level) == 2'b01) && !$past(busy));

  // R9
  reset_releases_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> stpclk_n && slp_n && bclk_en && (level == 2'b00));

  // R10
  reset_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_err |-> !rst_out && ($past(level) == 2'b11));

  // R12
  deep_strobes_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b11 && $past(level) == 2'b11) |-> $stable(stpclk_n) && $stable(slp_n));

  // R12
  sleep_strobes_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b10 && $past(level) == 2'b10 && !busy && !$past(busy))
      |-> $stable(stpclk_n) && $stable(slp_n));

  // R6
  clocks_restart_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_en) |-> pic_en && busy);

  // R5
  deep_clock_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b11 && !busy) |-> !bclk_en);

  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, busy}) && (ready || busy));
endmodule

bind clkstate_seq clkstate_chk i_chk (.*);

// File: tb/test_clkstate_seq.sv
`timescale 1ns/100ps
module test_clkstate_seq;
  localparam int EXIT_N   = 10;
  localparam int RELOCK_N = 40;

  logic clk, rst_n;
  logic grant_req, resume_req, sleep_req, wake_req, deep_req, deep_exit_req, rst_req, sg_ack;
  logic stpclk_n, slp_n, bclk_en, pic_en, rst_out, rst_err, busy, ready;
  logic [1:0] level;

  int checks, fails;
  string tag;

  clkstate_seq #(.EXIT_CYC(EXIT_N), .RELOCK_CYC(RELOCK_N)) i_clkstate_seq (
    .clk(clk), .rst_n(rst_n), .grant_req(grant_req), .resume_req(resume_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .deep_req(deep_req),
    .deep_exit_req(deep_exit_req), .rst_req(rst_req), .sg_ack(sg_ack),
    .stpclk_n(stpclk_n), .slp_n(slp_n), .bclk_en(bclk_en), .pic_en(pic_en),
    .rst_out(rst_out), .rst_err(rst_err), .level(level), .busy(busy), .ready(ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model: phase names and remaining-cycle count
  typedef enum int {P_NORMAL, P_ACKWAIT, P_GRANT, P_TO_NORMAL,
                    P_SLEEP, P_TO_GRANT, P_DEEP, P_PLL} phase_t;
  phase_t ph;
  int     remain;
  logic   m_rst, m_err;

  function automatic logic [1:0] m_level();
    case (ph)
      P_GRANT, P_TO_NORMAL:   return 2'b01;
      P_SLEEP, P_TO_GRANT:    return 2'b10;
      P_DEEP, P_PLL:          return 2'b11;
      default:                return 2'b00;
    endcase
  endfunction

  function automatic logic m_busy();
    return ph inside {P_ACKWAIT, P_TO_NORMAL, P_TO_GRANT, P_PLL};
  endfunction

  task automatic check(string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("level", level, m_level());
    check("busy", {1'b0, busy}, {1'b0, m_busy()});
    check("ready", {1'b0, ready}, {1'b0, !m_busy()});
    check("stpclk_n", {1'b0, stpclk_n}, {1'b0, ph inside {P_NORMAL, P_TO_NORMAL}});
    check("slp_n", {1'b0, slp_n}, {1'b0, !(ph inside {P_SLEEP, P_DEEP, P_PLL})});
    check("bclk_en", {1'b0, bclk_en}, {1'b0, ph != P_DEEP});
    check("pic_en", {1'b0, pic_en}, {1'b0, !(ph inside {P_SLEEP, P_DEEP})});
    check("rst_out", {1'b0, rst_out}, {1'b0, m_rst});
    check("rst_err", {1'b0, rst_err}, {1'b0, m_err});
  endtask

  task automatic model_step();
    logic stopped;
    stopped = (ph == P_DEEP) || (ph == P_PLL);
    m_rst = 1'b0;
    m_err = 1'b0;
    if (rst_req && !stopped) begin
      ph = P_NORMAL;
      m_rst = 1'b1;
      return;
    end
    if (rst_req) m_err = 1'b1;
    case (ph)
      P_NORMAL:  if (grant_req) ph = P_ACKWAIT;
      P_ACKWAIT: if (sg_ack) ph = P_GRANT;
      P_GRANT:   if (sleep_req) ph = P_SLEEP;
                 else if (resume_req) begin ph = P_TO_NORMAL; remain = EXIT_N; end
      P_SLEEP:   if (deep_req) ph = P_DEEP;
                 else if (wake_req) begin ph = P_TO_GRANT; remain = EXIT_N; end
      P_DEEP:    if (deep_exit_req) begin ph = P_PLL; remain = RELOCK_N; end
      default: begin
        remain--;
        if (remain == 0)
          ph = (ph == P_TO_NORMAL) ? P_NORMAL : (ph == P_TO_GRANT) ? P_GRANT : P_SLEEP;
      end
    endcase
  endtask

  // one cycle: check outputs, then drive the next inputs (one-hot request code)
  task automatic cyc(input int code);
    @(negedge clk);
    compare();
    {grant_req, resume_req, sleep_req, wake_req, deep_req, deep_exit_req, rst_req, sg_ack} = '0;
    case (code)
      1: grant_req = 1'b1;
      2: resume_req = 1'b1;
      3: sleep_req = 1'b1;
      4: wake_req = 1'b1;
      5: deep_req = 1'b1;
      6: deep_exit_req = 1'b1;
      7: rst_req = 1'b1;
      8: sg_ack = 1'b1;
      default: ;
    endcase
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    ph = P_NORMAL; remain = 0; m_rst = 1'b0; m_err = 1'b0;
    {grant_req, resume_req, sleep_req, wake_req, deep_req, deep_exit_req, rst_req, sg_ack} = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; idle(4);
    tag = "R3"; cyc(3); idle(3);          // sleep request in Normal ignored
    tag = "R2"; cyc(1); idle(2);
    tag = "R11"; cyc(3); cyc(2); idle(1); // ignored while waiting for acknowledge
    tag = "R2"; cyc(8); idle(2);
    tag = "R8"; cyc(2); idle(3);
    tag = "R11"; cyc(1); idle(EXIT_N);
    tag = "R2"; cyc(1); idle(1); cyc(8); idle(1);
    tag = "R4"; cyc(3); idle(3);
    tag = "R12"; cyc(3); idle(2);
    tag = "R5"; cyc(5); idle(3);
    tag = "R10"; cyc(7); idle(2);
    tag = "R6"; cyc(6); idle(5);
    tag = "R10"; cyc(7); idle(2);
    tag = "R11"; cyc(4); cyc(5); idle(RELOCK_N);
    tag = "R7"; cyc(4); idle(3);
    tag = "R3"; cyc(3); idle(EXIT_N);     // sleep request during the exit is ignored
    tag = "R4"; cyc(3); idle(2);
    tag = "R9"; cyc(7); idle(3);
    tag = "R2"; cyc(1); idle(1); cyc(8); idle(1);
    tag = "R9"; cyc(2); idle(3); cyc(7); idle(3);
    tag = "R1"; idle(2);
    summary();
    $finish;
  end
endmodule